// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is a byte-wide SPI master that moves a programmed burst of bytes over the serial bus. Software fills a transmit FIFO through a small register port. It sets a burst length and a transmit length, then sets a start bit. The engine clocks out the requested number of bytes. It takes as many as the transmit length allows from the FIFO and pads the rest with zero bytes. Each byte shifted in from MISO is placed in a receive FIFO, unless the discard control is set.

Serial timing comes from an external single-cycle enable, `bit_tick`. Every tick moves SCLK by one edge, so one byte takes sixteen ticks. Clock polarity, clock phase and bit order can be set. When the burst ends, a sticky completion flag is set. That flag drives a maskable, registered interrupt and is cleared by writing a one to it.

Register word addresses on `reg_addr`:
- 0: RX data (a read pops the FIFO)
- 1: TX data (a write pushes the FIFO)
- 2: control
- 3: interrupt enable
- 4: interrupt status
- 5: burst length
- 6: transmit length
- 7: FIFO fill status

Top module: `spi_burst_engine`

## Requirements
- R1: After synchronous reset the following all read 0: control, fill status, interrupt status and `irq`. SCLK idles low.
- R2: A burst of N bytes produces exactly 16·N SCLK edges. The first min(N, X) bytes sent on MOSI are the TX FIFO entries in push order, where X is the transmit length (address 6).
- R3: Once the transmit length is used up, every remaining byte of the burst is sent as 0x00.
- R4: SCLK idles at control bit 3 (CPOL). With control bit 2 (CPHA) at 0, the first MOSI bit is valid before the first edge and data is sampled on leading edges. With CPHA at 1, MOSI changes on leading edges and data is sampled on trailing edges.
- R5: With control bit 6 at 1, bytes are shifted LSB first in both directions. With it at 0, bytes are shifted MSB first.
- R6: Each received byte is pushed into the RX FIFO in bus order. A read of address 0 returns the oldest byte on `reg_rdata` in the next cycle and removes it.
- R7: With control bit 15 set, received bytes are dropped and the RX fill count does not rise.
- R8: Control bit 10 reads 1 from the start until the last byte ends, then clears by itself. At that same clock edge, status bit 16 is set.
- R9: Writing 1 to status bit 16 clears the flag. Writing 0 there has no effect.
- R10: `irq` is the status bit 16 AND enable bit 16 (address 3), registered one cycle.
- R11: A start with burst length 0 never enters the busy state and makes no SCLK edge. The completion flag is set at the next clock edge.
- R12: The fill status reads the RX count at bits 6:0 and the TX count at bits 22:16. Writing 1 to control bit 8 empties the TX FIFO. Writing 1 to control bit 9 empties the RX FIFO.
- R13: A start is ignored unless the same control write also sets bit 0 (enable) and bit 1 (master).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` |
| irq | output | 1 | Completion interrupt, registered |
| bit_tick | input | 1 | One-cycle enable that advances SCLK by one edge |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Read data appears on `reg_rdata` one clock after the read strobe, so every register read in the bench samples at the following falling edge. `irq` follows the flag and enable with one extra register. The bench therefore reads it only after the register writes that set its inputs have completed. A burst is timed only through the self-clearing start bit: the bench polls control until bit 10 drops, and only then checks the edge count, captured MOSI bytes, RX contents and the completion flag. The zero-length and gated starts are checked a few cycles after the write, which is long after the single cycle they are due in.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_RXD   = 3'd0,
    A_TXD   = 3'd1,
    A_CTRL  = 3'd2,
    A_IEN   = 3'd3,
    A_ISTAT = 3'd4,
    A_BURST = 3'd5,
    A_XMIT  = 3'd6,
    A_FSTAT = 3'd7
  } reg_addr_e;

  localparam int C_EN      = 0;
  localparam int C_MASTER  = 1;
  localparam int C_CPHA    = 2;
  localparam int C_CPOL    = 3;
  localparam int C_LSB     = 6;
  localparam int C_TXFLUSH = 8;
  localparam int C_RXFLUSH = 9;
  localparam int C_START   = 10;
  localparam int C_DISCARD = 15;
  localparam int I_DONE    = 16;
  localparam int F_TXPOS   = 16;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} seq_e;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [$clog2(DEPTH):0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R12: the fill count stays within the storage depth
  p_count_bound_r12: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb,
  input  logic         tick,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int EDGES = 2 * W;
  localparam int CW    = $clog2(EDGES);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [W-1:0]  tx_sh, rx_sh, rx_next, load_shift, tx_shift;
  logic [CW-1:0] cnt;
  logic          lead, sample_now, shift_now, load_bit, tx_bit;

  assign lead       = ~cnt[0];
  assign sample_now = lead ^ cpha;
  assign shift_now  = !sample_now && (cnt != LAST);

  always_comb begin
    load_bit   = lsb ? load_byte[0] : load_byte[W-1];
    load_shift = lsb ? (load_byte >> 1) : (load_byte << 1);
    tx_bit     = lsb ? tx_sh[0] : tx_sh[W-1];
    tx_shift   = lsb ? (tx_sh >> 1) : (tx_sh << 1);
    if (!sample_now)  rx_next = rx_sh;
    else if (lsb)     rx_next = {miso, rx_sh[W-1:1]};
    else              rx_next = {rx_sh[W-2:0], miso};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
        sclk <= cpol;
        if (!cpha) begin
          mosi  <= load_bit;
          tx_sh <= load_shift;
        end else begin
          tx_sh <= load_byte;
        end
      end else if (busy && tick) begin
        sclk  <= ~sclk;
        rx_sh <= rx_next;
        if (shift_now) begin
          mosi  <= tx_bit;
          tx_sh <= tx_shift;
        end
        if (cnt == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= rx_next;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!busy) begin
        sclk <= cpol;
      end
    end
  end

  // R4: an idle shifter parks SCLK at the polarity level
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> (sclk == $past(cpol)));
  // R2: SCLK only moves on a bit tick while a byte is in flight
  p_sclk_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !load) |=> $stable(sclk));
  // R2: a load always starts a byte
  p_load_busy_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24,
  parameter int DATA_W     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        bit_tick,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int FCW = $clog2(FIFO_DEPTH) + 1;

  seq_e              st;
  logic              en, master, cpha, cpol, lsb, discard;
  logic              ien, tc;
  logic [CNT_W-1:0]  burst_reg, xmit_reg, burst_left, xmit_left;
  logic              busy, wr_ctrl, start_go, tc_set;
  logic              tx_push, tx_pop, tx_full, tx_empty, tx_flush;
  logic              rx_push, rx_pop, rx_full, rx_empty, rx_flush;
  logic [DATA_W-1:0] tx_dout, rx_dout, load_byte, sh_rx;
  logic [FCW-1:0]    tx_cnt, rx_cnt;
  logic              sh_load, sh_busy, sh_done;
  logic [31:0]       ctrl_rd, fstat_rd;

  assign busy     = (st != S_IDLE);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign start_go = wr_ctrl && !busy && reg_wdata[C_START]
                    && reg_wdata[C_EN] && reg_wdata[C_MASTER];
  assign tx_flush = wr_ctrl && reg_wdata[C_TXFLUSH];
  assign rx_flush = wr_ctrl && reg_wdata[C_RXFLUSH];
  assign tx_push  = reg_wr && (reg_addr == A_TXD);
  assign rx_pop   = reg_rd && (reg_addr == A_RXD);
  assign sh_load  = (st == S_LOAD);
  assign tx_pop   = sh_load && (xmit_left != '0);
  assign load_byte = (xmit_left != '0 && !tx_empty) ? tx_dout : '0;
  assign rx_push  = (st == S_SHIFT) && sh_done && !discard;
  assign tc_set   = (start_go && burst_reg == '0)
                    || ((st == S_SHIFT) && sh_done && burst_left == CNT_W'(1));

  spi_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(tx_push),
    .din(reg_wdata[DATA_W-1:0]), .pop(tx_pop), .dout(tx_dout),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_push),
    .din(sh_rx), .pop(rx_pop), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_bit_shifter #(.W(DATA_W)) u_shf (
    .clk(clk), .rst(rst), .load(sh_load), .load_byte(load_byte),
    .cpol(cpol), .cpha(cpha), .lsb(lsb), .tick(bit_tick), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(sh_busy), .done(sh_done),
    .rx_byte(sh_rx));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      {en, master, cpha, cpol, lsb, discard} <= '0;
      ien <= 1'b0;
      burst_reg <= '0;  xmit_reg <= '0;
      burst_left <= '0; xmit_left <= '0;
    end else begin
      if (wr_ctrl && !busy) begin
        en      <= reg_wdata[C_EN];
        master  <= reg_wdata[C_MASTER];
        cpha    <= reg_wdata[C_CPHA];
        cpol    <= reg_wdata[C_CPOL];
        lsb     <= reg_wdata[C_LSB];
        discard <= reg_wdata[C_DISCARD];
      end
      if (reg_wr && reg_addr == A_IEN)   ien       <= reg_wdata[I_DONE];
      if (reg_wr && reg_addr == A_BURST) burst_reg <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_XMIT)  xmit_reg  <= reg_wdata[CNT_W-1:0];
      unique case (st)
        S_IDLE: if (start_go && burst_reg != '0) begin
          burst_left <= burst_reg;
          xmit_left  <= xmit_reg;
          st         <= S_LOAD;
        end
        S_LOAD: begin
          if (xmit_left != '0) xmit_left <= xmit_left - 1'b1;
          st <= S_SHIFT;
        end
        S_SHIFT: if (sh_done) begin
          burst_left <= burst_left - 1'b1;
          st <= (burst_left == CNT_W'(1)) ? S_IDLE : S_LOAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tc <= 1'b0;
    else if (tc_set)  tc <= 1'b1;
    else if (reg_wr && reg_addr == A_ISTAT && reg_wdata[I_DONE]) tc <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= tc && ien;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[C_EN]      = en;
    ctrl_rd[C_MASTER]  = master;
    ctrl_rd[C_CPHA]    = cpha;
    ctrl_rd[C_CPOL]    = cpol;
    ctrl_rd[C_LSB]     = lsb;
    ctrl_rd[C_START]   = busy;
    ctrl_rd[C_DISCARD] = discard;
    fstat_rd = '0;
    fstat_rd[FCW-1:0]               = rx_cnt;
    fstat_rd[F_TXPOS +: FCW]        = tx_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (reg_addr)
        A_RXD:   reg_rdata <= 32'(rx_dout);
        A_CTRL:  reg_rdata <= ctrl_rd;
        A_IEN:   reg_rdata <= 32'(ien) << I_DONE;
        A_ISTAT: reg_rdata <= 32'(tc) << I_DONE;
        A_BURST: reg_rdata <= 32'(burst_reg);
        A_XMIT:  reg_rdata <= 32'(xmit_reg);
        A_FSTAT: reg_rdata <= fstat_rd;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R8: the end of a burst always leaves the completion flag set
  p_end_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> tc);
  // R7: discard mode never grows the receive FIFO
  p_discard_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (discard && !wr_ctrl) |=> (rx_cnt <= $past(rx_cnt)));
  // R10: a masked flag never raises the interrupt
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq);
  // R11: an empty burst completes without going busy
  p_zero_burst_r11: assert property (@(posedge clk) disable iff (rst)
    (start_go && burst_reg == '0) |=> (!busy && tc));
  // R13: a start without enable and master is ignored
  p_start_gate_r13: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !busy && !(reg_wdata[C_EN] && reg_wdata[C_MASTER])) |=> !busy);
endmodule

// File: tb/sim_spi_burst_engine.sv
module sim_spi_burst_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sclk, mosi;
  logic        bit_tick = 1'b0;
  logic        miso = 1'b0;

  int nchk = 0, nfail = 0;

  // slave model state
  logic       s_cpol, s_cpha, s_lsb;
  int         s_edges, s_bit, s_nbytes;
  logic [7:0] s_cap;
  logic [7:0] mosi_got [64];
  logic [7:0] tx_exp [64];

  spi_burst_engine u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .bit_tick(bit_tick), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      bit_tick = ~bit_tick;
    end
  end

  function automatic logic [7:0] slave_byte(input int k);
    return 8'((k * 53 + 29) & 255);
  endfunction

  function automatic logic pick_bit(input logic [7:0] b, input int i, input logic l);
    return l ? b[i] : b[7 - i];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic slave_reset(input logic cp, input logic ph, input logic l);
    s_cpol = cp; s_cpha = ph; s_lsb = l;
    s_edges = 0; s_bit = 0; s_nbytes = 0; s_cap = '0;
    miso = pick_bit(slave_byte(0), 0, l);
  endtask

  task automatic slave_run();
    forever begin
      @(sclk);
      s_edges++;
      if ((sclk != s_cpol) != s_cpha) begin
        s_cap = s_lsb ? {mosi, s_cap[7:1]} : {s_cap[6:0], mosi};
        s_bit++;
        if (s_bit == 8) begin
          if (s_nbytes < 64) mosi_got[s_nbytes] = s_cap;
          s_nbytes++;
          s_bit = 0;
        end
        miso = pick_bit(slave_byte(s_nbytes), s_bit, s_lsb);
      end
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd2, v);
      if (!v[10]) return;
    end
    check(0, "R8 start never cleared", v, 32'h0);
  endtask

  task automatic run_burst(input logic cp, input logic ph, input logic l,
                           input logic disc, input int n, input int x);
    logic [31:0] base, v;
    base = 32'h3 | (32'(ph) << 2) | (32'(cp) << 3) | (32'(l) << 6) | (32'(disc) << 15);
    wr(3'd2, base | 32'h300);
    repeat (3) @(negedge clk);
    check(sclk == cp, "R4 idle SCLK level", 32'(sclk), 32'(cp));
    for (int i = 0; i < x; i++) begin
      tx_exp[i] = 8'($urandom);
      wr(3'd1, 32'(tx_exp[i]));
    end
    wr(3'd5, 32'(n));
    wr(3'd6, 32'(x));
    slave_reset(cp, ph, l);
    wr(3'd2, base | 32'h400);
    rd(3'd2, v);
    check(v[10] == 1'b1, "R8 start reads 1 while busy", v, base | 32'h400);
    wait_idle();
    check(s_edges == 16 * n, "R2 SCLK edge count", 32'(s_edges), 32'(16 * n));
    check(s_nbytes == n, "R2 bytes on bus", 32'(s_nbytes), 32'(n));
    for (int i = 0; i < n && i < 64; i++) begin
      logic [7:0] e;
      e = (i < x) ? tx_exp[i] : 8'h00;
      check(mosi_got[i] == e, (i < x) ? "R2/R4/R5 MOSI byte" : "R3 filler byte",
            32'(mosi_got[i]), 32'(e));
    end
    rd(3'd7, v);
    check(v == (disc ? 32'h0 : 32'(n)), disc ? "R7 discard keeps RX empty" : "R6 RX fill",
          v, disc ? 32'h0 : 32'(n));
    if (!disc) begin
      for (int i = 0; i < n; i++) begin
        rd(3'd0, v);
        check(v == 32'(slave_byte(i)), "R6/R4/R5 RX byte", v, 32'(slave_byte(i)));
      end
    end
    rd(3'd4, v);
    check(v == 32'h10000, "R8 completion flag", v, 32'h10000);
    wr(3'd4, 32'h10000);
    rd(3'd4, v);
    check(v == 32'h0, "R9 write-one clears", v, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    slave_reset(1'b0, 1'b0, 1'b0);
    fork
      slave_run();
    join_none
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd2, v); check(v == 0, "R1 control after reset", v, 0);
    rd(3'd7, v); check(v == 0, "R1 fill status after reset", v, 0);
    rd(3'd4, v); check(v == 0, "R1 flag after reset", v, 0);
    check(irq == 0, "R1 irq after reset", 32'(irq), 0);
    check(sclk == 0, "R1 SCLK after reset", 32'(sclk), 0);

    // R12 status layout and flush
    wr(3'd2, 32'h3);
    for (int i = 0; i < 3; i++) wr(3'd1, 32'(i));
    rd(3'd7, v); check(v == 32'h30000, "R12 TX count at bits 22:16", v, 32'h30000);
    wr(3'd2, 32'h103);
    rd(3'd7, v); check(v == 32'h0, "R12 TX flush", v, 32'h0);

    // R13 gated start
    wr(3'd5, 32'd2);
    slave_reset(1'b0, 1'b0, 1'b0);
    wr(3'd2, 32'h400);
    repeat (6) @(negedge clk);
    rd(3'd2, v); check(v[10] == 0, "R13 start without enable", v, 32'h0);
    check(s_edges == 0, "R13 no SCLK edges", 32'(s_edges), 0);
    rd(3'd4, v); check(v == 0, "R13 no completion", v, 0);

    // R11 zero-length burst
    wr(3'd5, 32'd0);
    wr(3'd2, 32'h403);
    rd(3'd2, v); check(v[10] == 0, "R11 never busy", v, 32'h3);
    rd(3'd4, v); check(v == 32'h10000, "R11 flag set", v, 32'h10000);
    check(s_edges == 0, "R11 no SCLK edges", 32'(s_edges), 0);

    // R9 write zero has no effect, R10 masking
    wr(3'd4, 32'h0);
    rd(3'd4, v); check(v == 32'h10000, "R9 write zero ignored", v, 32'h10000);
    check(irq == 0, "R10 masked irq", 32'(irq), 0);
    wr(3'd3, 32'h10000);
    @(negedge clk);
    check(irq == 1, "R10 enabled irq", 32'(irq), 1);
    wr(3'd4, 32'h10000);
    @(negedge clk);
    check(irq == 0, "R10 irq drops on clear", 32'(irq), 0);
    wr(3'd3, 32'h0);

    // directed bursts
    run_burst(1'b0, 1'b0, 1'b0, 1'b0, 4, 4);
    run_burst(1'b1, 1'b1, 1'b1, 1'b0, 5, 0);
    run_burst(1'b1, 1'b0, 1'b0, 1'b0, 6, 2);
    run_burst(1'b0, 1'b1, 1'b1, 1'b1, 3, 3);
    run_burst(1'b0, 1'b0, 1'b0, 1'b0, 64, 64);

    // random bursts
    for (int t = 0; t < 20; t++) begin
      int n, x;
      n = 1 + int'($urandom_range(11));
      x = int'($urandom_range(n));
      run_burst(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), n, x);
    end

    // R12 RX flush
    run_burst(1'b0, 1'b0, 1'b0, 1'b0, 2, 0);
    wr(3'd5, 32'd3);
    wr(3'd6, 32'd0);
    slave_reset(1'b0, 1'b0, 1'b0);
    wr(3'd2, 32'h403);
    wait_idle();
    wr(3'd2, 32'h203);
    rd(3'd7, v); check(v == 0, "R12 RX flush", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule